// File: doc/BRIEF.md
# Coefficient Compress and Bit Packer

This block turns a set of 256-coefficient polynomials into a packed byte stream. It fetches one coefficient at a time from a synchronous-read coefficient memory. It reduces each coefficient to `d` bits by scaled rounding. It then appends those bits to a small accumulator and writes each complete byte, low bits first, to a byte-wide output memory.

A single run, started by a one-cycle `start` pulse, covers two regions back to back:

- **First region:** the first `K` polynomials, packed at width `du`.
- **Second region:** one further polynomial, packed at width `dv`.

The output byte address runs on from the first region into the second without restarting. The two regions therefore form one contiguous stream. A one-cycle `done` pulse marks the end of the run.

Top module: `coeff_compress_packer`

## Requirements
- R1: Each coefficient x (0..3328) becomes round(x·2^d/3329) mod 2^d, with halves rounded up. For d=8, each output byte equals exactly one compressed coefficient.
- R2: Compressed values are packed least-significant bit first. Bit j of the stream lands in byte j/8, bit position j mod 8. A single 11-bit value may straddle three bytes.
- R3: The first region reads polynomials 0..K-1 at width du. Coefficient i of polynomial p is read from address p·256+i, in increasing i.
- R4: The second region reads polynomial K (addresses K·256+i) at width dv. Its first byte is written at the address directly after the last byte of the first region.
- R5: A run writes exactly 32·du·K + 32·dv bytes, to addresses 0 upward, with no gaps.
- R6: The bit accumulator is empty at every polynomial boundary. The first byte of every polynomial carries only that polynomial's bits, starting at bit 0.
- R7: The read data returned in the cycle after `rd_en` is the value that gets compressed. `rd_en` is never high for two cycles running.
- R8: `done` pulses high for exactly one cycle, in the cycle after the final byte write. No read or write follows until the next `start`.
- R9: K, du and dv are sampled at `start`. A `start` pulse or a change of the settings while a run is in progress has no effect on that run.
- R10: After reset, `done`, `wr_en` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request, taken only when idle |
| k_sel | input | 3 | Polynomial count of the first region (2..4) |
| du | input | 4 | Bit width of the first region (1..11) |
| dv | input | 4 | Bit width of the second region (1..11) |
| rd_en | output | 1 | Coefficient memory read enable |
| rd_addr | output | 11 | Coefficient memory address |
| rd_data | input | 12 | Coefficient read data, valid the cycle after rd_en |
| wr_en | output | 1 | Output byte write enable |
| wr_addr | output | 11 | Output byte address |
| wr_data | output | 8 | Output byte |
| done | output | 1 | Run complete pulse |

## Verification
The hardest case to reach from the ports is the hand-off between the two regions. There, the width changes between two polynomials while the write address must run on unbroken and the accumulator must be empty.

The stimulus reaches it with width pairs chosen so that the two regions differ in width. These include:

- 11 then 5
- 1 then 11
- 10 then 4

In each case the behavioural model predicts every byte address and value around the join.

A run that pulses `start` and changes all settings mid-stream exercises the sampling rule of R9.

// File: rtl/pk_pkg.sv
package pk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPT,
    ST_COMP,
    ST_APPEND,
    ST_DRAIN
  } pk_state_t;
endpackage

// File: rtl/pk_compress.sv
module pk_compress #(
  parameter int CW   = 12,
  parameter int Q    = 3329,
  parameter int DMAX = 11,
  parameter int DW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            comp_en,
  input  logic [CW-1:0]   x_in,
  input  logic [DW-1:0]   d,
  output logic [DMAX-1:0] y_out
);
  localparam int NUM_W = CW + DMAX + 2;
  localparam int DIV   = 2 * Q;
  localparam int SH    = NUM_W + $clog2(DIV);
  localparam int PW    = NUM_W + SH;
  localparam logic [63:0] MAGIC = ((64'd1 << SH) + 64'(DIV) - 64'd1) / 64'(DIV);

  logic [CW-1:0]   x_q;
  logic [NUM_W-1:0] num;
  logic [PW-1:0]   prod;
  logic [PW-1:0]   quo;
  logic [DMAX-1:0] mask;
  logic [DMAX-1:0] y_c;

  always_comb begin
    num  = NUM_W'(x_q) << d;
    num  = (num << 1) + NUM_W'(Q);
    prod = PW'(num) * PW'(MAGIC);
    quo  = prod >> SH;
    mask = (DMAX'(1) << d) - DMAX'(1);
    y_c  = DMAX'(quo) & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      y_out <= '0;
    end else begin
      if (cap_en)  x_q   <= x_in;
      if (comp_en) y_out <= y_c;
    end
  end

  AST_COEFF_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (x_in < CW'(Q)));  // R1
endmodule

// File: rtl/pk_packer.sv
module pk_packer #(
  parameter int DMAX  = 11,
  parameter int DW    = 4,
  parameter int OW    = 11,
  parameter int ACC_W = DMAX + 7,
  parameter int CNTW  = $clog2(ACC_W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            app_en,
  input  logic [DMAX-1:0] app_val,
  input  logic [DW-1:0]   app_d,
  input  logic            drain_en,
  output logic            has_byte,
  output logic [CNTW-1:0] bits_held,
  output logic            wr_en,
  output logic [OW-1:0]   wr_addr,
  output logic [7:0]      wr_data
);
  logic [ACC_W-1:0] acc;
  logic [OW-1:0]    ptr;

  assign has_byte = (bits_held >= CNTW'(8));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      bits_held <= '0;
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clr) begin
        acc       <= '0;
        bits_held <= '0;
        ptr       <= '0;
      end else if (app_en) begin
        acc       <= acc | (ACC_W'(app_val) << bits_held);
        bits_held <= bits_held + CNTW'(app_d);
      end else if (drain_en && has_byte) begin
        wr_en     <= 1'b1;
        wr_data   <= acc[7:0];
        wr_addr   <= ptr;
        acc       <= acc >> 8;
        bits_held <= bits_held - CNTW'(8);
        ptr       <= ptr + 1'b1;
      end
    end
  end

  AST_ACC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    app_en |-> (bits_held < CNTW'(8)));  // R2
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));  // R5
endmodule

// File: rtl/pk_seq.sv
module pk_seq
  import pk_pkg::*;
#(
  parameter int N    = 256,
  parameter int KW   = 3,
  parameter int DW   = 4,
  parameter int AW   = 11,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [KW-1:0]   k_in,
  input  logic [DW-1:0]   du_in,
  input  logic [DW-1:0]   dv_in,
  input  logic            has_byte,
  input  logic [CNTW-1:0] bits_held,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  output logic            clr,
  output logic            cap_en,
  output logic            comp_en,
  output logic            app_en,
  output logic            drain_en,
  output logic [DW-1:0]   cur_d,
  output logic            done
);
  localparam int IW = $clog2(N);

  pk_state_t     st;
  logic [KW-1:0] k_q;
  logic [DW-1:0] du_q, dv_q;
  logic          region;
  logic [KW-1:0] poly;
  logic [IW-1:0] idx;
  logic [KW-1:0] poly_sel;
  logic          last_idx;

  assign poly_sel = region ? k_q : poly;
  assign rd_addr  = AW'(poly_sel) * AW'(N) + AW'(idx);
  assign rd_en    = (st == ST_ISSUE);
  assign cap_en   = (st == ST_CAPT);
  assign comp_en  = (st == ST_COMP);
  assign app_en   = (st == ST_APPEND);
  assign drain_en = (st == ST_DRAIN);
  assign clr      = (st == ST_IDLE) && start;
  assign cur_d    = region ? dv_q : du_q;
  assign last_idx = (idx == IW'(N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      k_q    <= '0;
      du_q   <= '0;
      dv_q   <= '0;
      region <= 1'b0;
      poly   <= '0;
      idx    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          k_q    <= k_in;
          du_q   <= du_in;
          dv_q   <= dv_in;
          region <= 1'b0;
          poly   <= '0;
          idx    <= '0;
          st     <= ST_ISSUE;
        end
        ST_ISSUE:  st <= ST_CAPT;
        ST_CAPT:   st <= ST_COMP;
        ST_COMP:   st <= ST_APPEND;
        ST_APPEND: st <= ST_DRAIN;
        ST_DRAIN: if (!has_byte) begin
          if (!last_idx) begin
            idx <= idx + 1'b1;
            st  <= ST_ISSUE;
          end else if (!region && (poly != k_q - 1'b1)) begin
            poly <= poly + 1'b1;
            idx  <= '0;
            st   <= ST_ISSUE;
          end else if (!region) begin
            region <= 1'b1;
            poly   <= '0;
            idx    <= '0;
            st     <= ST_ISSUE;
          end else begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);  // R7
  AST_POLY_BOUNDARY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DRAIN && !has_byte && last_idx) |-> (bits_held == '0));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
endmodule

// File: rtl/coeff_compress_packer.sv
module coeff_compress_packer #(
  parameter int N    = 256,
  parameter int CW   = 12,
  parameter int Q    = 3329,
  parameter int KMAX = 4,
  parameter int DMAX = 11,
  parameter int KW   = $clog2(KMAX + 1),
  parameter int DW   = $clog2(DMAX + 1),
  parameter int AW   = $clog2((KMAX + 1) * N),
  parameter int OW   = $clog2((KMAX + 1) * N * DMAX / 8 + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] k_sel,
  input  logic [DW-1:0] du,
  input  logic [DW-1:0] dv,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [CW-1:0] rd_data,
  output logic          wr_en,
  output logic [OW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done
);
  localparam int ACC_W = DMAX + 7;
  localparam int CNTW  = $clog2(ACC_W + 1);

  logic            clr, cap_en, comp_en, app_en, drain_en, has_byte;
  logic [CNTW-1:0] bits_held;
  logic [DW-1:0]   cur_d;
  logic [DMAX-1:0] cval;

  pk_seq #(.N(N), .KW(KW), .DW(DW), .AW(AW), .CNTW(CNTW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .k_in(k_sel), .du_in(du), .dv_in(dv),
    .has_byte(has_byte), .bits_held(bits_held), .rd_en(rd_en), .rd_addr(rd_addr),
    .clr(clr), .cap_en(cap_en), .comp_en(comp_en), .app_en(app_en),
    .drain_en(drain_en), .cur_d(cur_d), .done(done)
  );

  pk_compress #(.CW(CW), .Q(Q), .DMAX(DMAX), .DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .cap_en(cap_en), .comp_en(comp_en),
    .x_in(rd_data), .d(cur_d), .y_out(cval)
  );

  pk_packer #(.DMAX(DMAX), .DW(DW), .OW(OW), .ACC_W(ACC_W), .CNTW(CNTW)) u_pack (
    .clk(clk), .rst(rst), .clr(clr), .app_en(app_en), .app_val(cval),
    .app_d(cur_d), .drain_en(drain_en), .has_byte(has_byte),
    .bits_held(bits_held), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_en && !wr_en));  // R8
endmodule

// File: tb/tb_coeff_compress_packer.sv
module tb_coeff_compress_packer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 256;
  localparam int Q = 3329;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  k_sel = 3'd2;
  logic [3:0]  du = 4'd10, dv = 4'd4;
  logic        rd_en, wr_en, done;
  logic [10:0] rd_addr, wr_addr;
  logic [11:0] rd_data;
  logic [7:0]  wr_data;

  int mem [0:5*N-1];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coeff_compress_packer dut (
    .clk(clk), .rst(rst), .start(start), .k_sel(k_sel), .du(du), .dv(dv),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  always @(posedge clk) rd_data <= rd_en ? 12'(mem[rd_addr]) : 12'hFFF;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int compress(input int x, input int d);
    return (((x * (1 << d)) * 2 + Q) / (2 * Q)) % (1 << d);
  endfunction

  task automatic run(input int k, input int d1, input int d2, input string dtag, input bit disturb);
    int exp_b[$];
    int exp_rd[$];
    int first_of_poly[$];
    longint acc = 0;
    int nb = 0;
    int c1 = 0;
    int wcnt = 0;
    int rcnt = 0;
    int cyc = 0;
    bit prev_wr = 0;
    bit fin = 0;
    for (int p = 0; p <= k; p++) begin
      int d = (p < k) ? d1 : d2;
      first_of_poly.push_back(exp_b.size());
      for (int i = 0; i < N; i++) begin
        exp_rd.push_back(p * N + i);
        acc = acc | (longint'(compress(mem[p * N + i], d)) << nb);
        nb += d;
        while (nb >= 8) begin
          exp_b.push_back(int'(acc & 255));
          acc = acc >> 8;
          nb -= 8;
        end
      end
      if (p == k - 1) c1 = exp_b.size();
    end
    @(negedge clk);
    k_sel = 3'(k); du = 4'(d1); dv = 4'(d2); start = 1'b1;
    while (!fin) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (disturb && cyc == 50) begin
        start = 1'b1; k_sel = 3'd2; du = 4'd3; dv = 4'd7;
      end
      if (rd_en) begin
        int ea = (rcnt < exp_rd.size()) ? exp_rd[rcnt] : -1;
        chk(int'(rd_addr) == ea, (rcnt < k * N) ? "R3 read address" : "R4 read address", int'(rd_addr), ea);
        rcnt++;
      end
      if (wr_en) begin
        int eb = (wcnt < exp_b.size()) ? exp_b[wcnt] : -1;
        bool_first: begin end
        if (wcnt inside {first_of_poly}) chk(int'(wr_data) == eb, "R6 first byte of polynomial", int'(wr_data), eb);
        else chk(int'(wr_data) == eb, dtag, int'(wr_data), eb);
        chk(int'(wr_addr) == wcnt, (wcnt < c1) ? "R5 write address" : "R4 write address", int'(wr_addr), wcnt);
        wcnt++;
      end
      if (done) begin
        chk(prev_wr, "R8 done follows last write", int'(prev_wr), 1);
        chk(wcnt == 32 * d1 * k + 32 * d2, disturb ? "R9 byte count with disturbed settings" : "R5 byte count",
            wcnt, 32 * d1 * k + 32 * d2);
        chk(c1 == 32 * d1 * k, "R4 first region size", c1, 32 * d1 * k);
        fin = 1;
      end
      prev_wr = wr_en;
      if (cyc > 60000) begin
        chk(0, "R8 watchdog", cyc, 0);
        fin = 1;
      end
    end
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(!done && !wr_en && !rd_en, "R8 quiet after done", int'({done, wr_en, rd_en}), 0);
    end
  endtask

  initial begin
    for (int a = 0; a < 5 * N; a++) mem[a] = (a * 97 + 13 + a / 7) % Q;
    mem[0] = 3328; mem[1] = 0; mem[2] = 1664; mem[3] = 1665;
    mem[N] = 3328; mem[2 * N] = 1; mem[4 * N + 5] = 3328;
    repeat (3) @(negedge clk);
    chk(!done && !wr_en && !rd_en, "R10 reset outputs", int'({done, wr_en, rd_en}), 0);
    rst = 1'b0;
    run(2, 10, 4, "R7 captured read data", 0);
    run(3, 10, 4, "R2 packed byte", 0);
    run(4, 11, 5, "R2 packed byte (11-bit straddle)", 0);
    run(2, 8, 8, "R1 compressed value", 0);
    run(3, 1, 11, "R2 packed byte", 0);
    run(4, 11, 11, "R9 byte under disturbance", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule